// File: doc/BRIEF.md
# Register Command Executor

This block walks a packed instruction stream held in a small local command memory and turns each instruction into one or more writes on a register-bus master port. Every instruction takes a pair of 32-bit words and starts at an even word index. The second word of the pair always carries the opcode and the target register offset. The first word carries either the data value, for a single write, or the number of data words that follow, for an auto-increment burst.

Before a run, the command memory is filled through a dedicated load port, and the start and end word indices are presented on the pointer inputs. Writing the enable bit as 1 through the control port starts a run, provided the block is idle. The executor then fetches, decodes and issues writes one at a time over a valid/ready handshake. Busy stays high for the whole run. An unknown opcode stops the run and raises an error flag that stays set.

Top module: `regcmd_exec`

## Requirements
- R1: Instructions start at even word indices. The opcode is bits 31:24 of the odd (second) word. Code 0x01 selects a single write and 0x09 selects a burst.
- R2: A single write produces exactly one bus write. Its offset is bits 19:0 of the opcode word, its byte enables are bits 23:20 of that word, and its data is the even (first) word.
- R3: A burst takes its data-word count from the even word. It issues that many bus writes, in memory order, all to the offset in bits 19:0 of the opcode word, with all four byte enables set whatever bits 23:20 hold.
- R4: When a burst count is odd, the word after the last data word is padding. It is never issued, and the next instruction is fetched at the following even index.
- R5: A control write with enable=1 while idle starts a run at the start pointer. The run ends when the fetch pointer reaches the end pointer, so a run with start equal to end issues nothing. Busy is only ever high while enable is 1.
- R6: Busy is high from the cycle after the starting control write. It stays high through the cycle after the final handshake and is low in the cycle after that.
- R7: A control write that arrives while busy is ignored: enable keeps its value and the run continues. A control write with enable=0 while idle clears enable.
- R8: While valid is high and ready is low, offset, byte enables and data stay unchanged. Only one write is outstanding at a time, and valid is never high while idle.
- R9: An opcode other than 0x01 or 0x09 raises the error flag and ends the run with busy low. That instruction and every later one issue no write. The flag stays set through later runs until reset.
- R10: After reset, enable, busy, error and valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_we | input | 1 | Command memory write strobe |
| load_addr | input | AW | Command memory word index to write |
| load_data | input | 32 | Command memory word to write |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_enable | input | 1 | Enable value carried by a control write |
| start_ptr | input | AW | First word index of the run, even |
| end_ptr | input | AW | Word index at which the run stops |
| enable_o | output | 1 | Enable bit of the control register |
| busy_o | output | 1 | Run in progress |
| error_o | output | 1 | Sticky unknown-opcode flag |
| bus_valid_o | output | 1 | Register write request valid |
| bus_ready_i | input | 1 | Register bus accepts the request |
| bus_addr_o | output | 20 | Register offset of the write |
| bus_be_o | output | 4 | Byte enables of the write |
| bus_data_o | output | 32 | Data of the write |

## Verification
The properties assume that the bus slave's ready is a plain input that may fall and rise in any cycle, and that the pointers and the memory contents are not changed during a run. The stimulus loads memory and sets the pointers only while busy is low. It toggles ready from a shift-register pattern or holds it low for a while, and it sends control writes both during runs and between them. Each run's end pointer lands exactly on an instruction boundary. Even start indices are used throughout, so the properties never meet a misaligned stream.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned OFS_W  = 20;
    localparam int unsigned BE_W   = 4;

    localparam logic [7:0] OP_SINGLE = 8'h01;
    localparam logic [7:0] OP_BURST  = 8'h09;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_BURST,
        ST_WAIT
    } exec_state_e;

    typedef struct packed {
        logic [OFS_W-1:0]  ofs;
        logic [BE_W-1:0]   be;
        logic [WORD_W-1:0] data;
    } bus_req_t;
endpackage

// File: rtl/regcmd_ram.sv
module regcmd_ram #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // both words of an instruction pair are visible in the same cycle
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/regcmd_wrport.sv
module regcmd_wrport
    import regcmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     issue_i,
    input  bus_req_t req_i,
    input  logic     ready_i,
    output logic     valid_o,
    output bus_req_t req_o
);
    typedef struct packed {
        logic     valid;
        bus_req_t req;
    } wp_t;

    wp_t wp_d, wp_q;

    always_comb begin
        wp_d = wp_q;
        if (wp_q.valid && ready_i) begin
            wp_d.valid = 1'b0;
        end
        if (issue_i) begin
            wp_d.valid = 1'b1;
            wp_d.req   = req_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
        end else begin
            wp_q <= wp_d;
        end
    end

    assign valid_o = wp_q.valid;
    assign req_o   = wp_q.req;
endmodule

// File: rtl/regcmd_exec.sv
module regcmd_exec
    import regcmd_pkg::*;
#(
    parameter int unsigned AW    = 6,
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_we,
    input  logic [AW-1:0]     load_addr,
    input  logic [WORD_W-1:0] load_data,
    input  logic              ctrl_we,
    input  logic              ctrl_enable,
    input  logic [AW-1:0]     start_ptr,
    input  logic [AW-1:0]     end_ptr,
    output logic              enable_o,
    output logic              busy_o,
    output logic              error_o,
    output logic              bus_valid_o,
    input  logic              bus_ready_i,
    output logic [OFS_W-1:0]  bus_addr_o,
    output logic [BE_W-1:0]   bus_be_o,
    output logic [WORD_W-1:0] bus_data_o
);
    localparam logic [AW-1:0] STEP1 = AW'(1);
    localparam logic [AW-1:0] STEP2 = AW'(2);

    typedef struct packed {
        exec_state_e      st;
        exec_state_e      ret;
        logic [AW-1:0]    ptr;
        logic [AW-1:0]    endp;
        logic [CNT_W-1:0] left;
        logic [OFS_W-1:0] ofs;
        logic             en;
        logic             err;
    } ex_t;

    ex_t ex_d, ex_q;

    logic [WORD_W-1:0] w_even, w_odd;
    logic [AW-1:0]     ptr_odd;
    logic [AW-1:0]     ptr_align;
    logic              issue;
    bus_req_t          req_new;
    bus_req_t          req_cur;
    logic              wr_done;

    assign ptr_odd   = ex_q.ptr + STEP1;
    assign ptr_align = ex_q.ptr + AW'(ex_q.ptr[0]);

    regcmd_ram #(.AW(AW), .DW(WORD_W)) u_ram (
        .clk     (clk),
        .we      (load_we),
        .waddr   (load_addr),
        .wdata   (load_data),
        .raddr_a (ex_q.ptr),
        .rdata_a (w_even),
        .raddr_b (ptr_odd),
        .rdata_b (w_odd)
    );

    regcmd_wrport u_wrport (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue_i (issue),
        .req_i   (req_new),
        .ready_i (bus_ready_i),
        .valid_o (bus_valid_o),
        .req_o   (req_cur)
    );

    assign wr_done = bus_valid_o && bus_ready_i;

    always_comb begin
        ex_d    = ex_q;
        issue   = 1'b0;
        req_new = '{ofs: w_odd[OFS_W-1:0], be: w_odd[23:20], data: w_even};
        unique case (ex_q.st)
            ST_IDLE: begin
                if (ctrl_we) begin
                    ex_d.en = ctrl_enable;
                    if (ctrl_enable) begin
                        ex_d.st   = ST_FETCH;
                        ex_d.ptr  = start_ptr;
                        ex_d.endp = end_ptr;
                    end
                end
            end
            ST_FETCH: begin
                if (ex_q.ptr >= ex_q.endp) begin
                    ex_d.st = ST_IDLE;
                end else if (w_odd[31:24] == OP_SINGLE) begin
                    issue     = 1'b1;
                    ex_d.ptr  = ex_q.ptr + STEP2;
                    ex_d.ret  = ST_FETCH;
                    ex_d.st   = ST_WAIT;
                end else if (w_odd[31:24] == OP_BURST) begin
                    ex_d.ofs  = w_odd[OFS_W-1:0];
                    ex_d.left = w_even[CNT_W-1:0];
                    ex_d.ptr  = ex_q.ptr + STEP2;
                    ex_d.st   = ST_BURST;
                end else begin
                    ex_d.err  = 1'b1;
                    ex_d.st   = ST_IDLE;
                end
            end
            ST_BURST: begin
                if (ex_q.left == '0) begin
                    // skip the padding word so the next pair is aligned
                    ex_d.ptr = ptr_align;
                    ex_d.st  = (ptr_align >= ex_q.endp) ? ST_IDLE : ST_FETCH;
                end else begin
                    issue     = 1'b1;
                    req_new   = '{ofs: ex_q.ofs, be: '1, data: w_even};
                    ex_d.ptr  = ex_q.ptr + STEP1;
                    ex_d.left = ex_q.left - CNT_W'(1);
                    ex_d.ret  = ST_BURST;
                    ex_d.st   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (wr_done) begin
                    ex_d.st = ex_q.ret;
                end
            end
            default: ex_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_q <= '{st: ST_IDLE, ret: ST_IDLE, default: '0};
        end else begin
            ex_q <= ex_d;
        end
    end

    assign enable_o   = ex_q.en;
    assign busy_o     = (ex_q.st != ST_IDLE);
    assign error_o    = ex_q.err;
    assign bus_addr_o = req_cur.ofs;
    assign bus_be_o   = req_cur.be;
    assign bus_data_o = req_cur.data;
endmodule

// File: rtl/regcmd_exec_chk.sv
module regcmd_exec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_we,
    input logic        enable_o,
    input logic        busy_o,
    input logic        error_o,
    input logic        bus_valid_o,
    input logic        bus_ready_i,
    input logic [19:0] bus_addr_o,
    input logic [3:0]  bus_be_o,
    input logic [31:0] bus_data_o
);
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o)
            && $stable(bus_be_o) && $stable(bus_data_o));

    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_valid_o);

    assert_ctrl_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && ctrl_we |=> enable_o == $past(enable_o));

    assert_busy_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> enable_o);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |=> error_o);

    assert_err_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> !busy_o && !bus_valid_o);
endmodule

bind regcmd_exec regcmd_exec_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (ctrl_we),
    .enable_o    (enable_o),
    .busy_o      (busy_o),
    .error_o     (error_o),
    .bus_valid_o (bus_valid_o),
    .bus_ready_i (bus_ready_i),
    .bus_addr_o  (bus_addr_o),
    .bus_be_o    (bus_be_o),
    .bus_data_o  (bus_data_o)
);

// File: tb/regcmd_exec_tb_top.sv
`timescale 1ns/1ps
module regcmd_exec_tb_top;
    import regcmd_pkg::*;

    localparam int unsigned AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_we = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [31:0]   load_data = '0;
    logic          ctrl_we = 1'b0;
    logic          ctrl_enable = 1'b0;
    logic [AW-1:0] start_ptr = '0;
    logic [AW-1:0] end_ptr = '0;
    logic          enable_o, busy_o, error_o, bus_valid_o;
    logic          bus_ready_i = 1'b1;
    logic [19:0]   bus_addr_o;
    logic [3:0]    bus_be_o;
    logic [31:0]   bus_data_o;

    always #2 clk = ~clk;

    regcmd_exec #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .ctrl_we(ctrl_we), .ctrl_enable(ctrl_enable),
        .start_ptr(start_ptr), .end_ptr(end_ptr), .enable_o(enable_o),
        .busy_o(busy_o), .error_o(error_o), .bus_valid_o(bus_valid_o),
        .bus_ready_i(bus_ready_i), .bus_addr_o(bus_addr_o),
        .bus_be_o(bus_be_o), .bus_data_o(bus_data_o)
    );

    int       checks = 0;
    int       errors = 0;
    int       cyc = 0;
    int       last_hs = 0;
    int       hs_count = 0;
    int       ready_mode = 0;
    int       wp = 0;
    logic [7:0] lfsr = 8'hA5;
    bus_req_t exp_q[$];

    task automatic check_eq(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // ready pattern, changed just after the active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            case (ready_mode)
                0: bus_ready_i = 1'b1;
                1: begin
                    bus_ready_i = lfsr[0] | lfsr[3];
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                end
                default: bus_ready_i = 1'b0;
            endcase
        end
    end

    // monitor: every accepted write is compared with the scoreboard head
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bus_valid_o && bus_ready_i) begin
                last_hs = cyc;
                hs_count++;
                if (exp_q.size() == 0) begin
                    check_eq("R2/R3/R4/R9 unexpected write",
                             {8'h0, bus_addr_o, bus_be_o, bus_data_o}, 64'h0);
                end else begin
                    bus_req_t e;
                    e = exp_q.pop_front();
                    check_eq("R2/R3 write content",
                             {8'h0, bus_addr_o, bus_be_o, bus_data_o}, {8'h0, e});
                end
            end
        end
    end

    task automatic load_word(int a, logic [31:0] d);
        @(negedge clk);
        load_we = 1'b1;
        load_addr = AW'(a);
        load_data = d;
        @(negedge clk);
        load_we = 1'b0;
    endtask

    task automatic put_single(logic [19:0] ofs, logic [3:0] be, logic [31:0] d, bit expect_it);
        load_word(wp, d);
        load_word(wp + 1, {OP_SINGLE, be, ofs});
        if (expect_it) exp_q.push_back('{ofs: ofs, be: be, data: d});
        wp += 2;
    endtask

    task automatic put_burst(logic [19:0] ofs, int n, logic [31:0] base);
        load_word(wp, 32'(n));
        load_word(wp + 1, {OP_BURST, 4'h3, ofs});
        wp += 2;
        for (int i = 0; i < n; i++) begin
            logic [31:0] v;
            v = base + 32'(i) * 32'h0101_0101;
            load_word(wp, v);
            exp_q.push_back('{ofs: ofs, be: 4'hF, data: v});
            wp++;
        end
        if (n % 2 == 1) begin
            load_word(wp, 32'h0);
            wp++;
        end
    endtask

    task automatic ctrl_write(bit en);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_enable = en;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic run(int s, int e, bit exp_err, string tag);
        int t;
        int hs0;
        hs0 = hs_count;
        @(negedge clk);
        start_ptr = AW'(s);
        end_ptr = AW'(e);
        ctrl_write(1'b1);
        check_eq({tag, " R6 busy after start"}, 64'(busy_o), 64'd1);
        t = 0;
        while (busy_o && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (hs_count != hs0) begin
            check_eq({tag, " R6 busy fall timing"}, 64'(cyc), 64'(last_hs + 2));
        end
        check_eq({tag, " R2/R3 all writes issued"}, 64'(exp_q.size()), 64'd0);
        check_eq({tag, " R9 error flag"}, 64'(error_o), 64'(exp_err));
        exp_q.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check_eq("R10 enable", 64'(enable_o), 64'd0);
        check_eq("R10 busy", 64'(busy_o), 64'd0);
        check_eq("R10 error", 64'(error_o), 64'd0);
        check_eq("R10 valid", 64'(bus_valid_o), 64'd0);

        // R1 R2: single writes, ready always high
        ready_mode = 0;
        wp = 0;
        put_single(20'h12345, 4'b0101, 32'hDEAD_BEEF, 1'b1);
        put_single(20'hFFFFF, 4'b1000, 32'h0000_00A5, 1'b1);
        put_single(20'h00000, 4'hF, 32'hFFFF_FFFF, 1'b1);
        run(0, wp, 1'b0, "R1 R2 singles");
        check_eq("R5 enable kept after run", 64'(enable_o), 64'd1);

        // R3 R4: bursts of odd and even length mixed with singles, random ready
        ready_mode = 1;
        begin
            int s;
            s = wp;
            put_burst(20'h0A000, 3, 32'h1000_0000);
            put_single(20'h0B00C, 4'b0011, 32'h1234_5678, 1'b1);
            put_burst(20'h0B004, 2, 32'h2000_0000);
            put_burst(20'h0C008, 1, 32'h3000_0000);
            put_single(20'h0D000, 4'b0110, 32'hCAFE_F00D, 1'b1);
            run(s, wp, 1'b0, "R3 R4 bursts");
        end

        // R5: empty run issues nothing
        ready_mode = 0;
        begin
            int h0;
            h0 = hs_count;
            run(wp, wp, 1'b0, "R5 empty run");
            check_eq("R5 empty run write count", 64'(hs_count - h0), 64'd0);
        end

        // R7 R8: control write while busy, request held while ready low
        ready_mode = 2;
        begin
            int s;
            logic [31:0] held;
            s = wp;
            put_single(20'h54321, 4'b1010, 32'h0BAD_CAFE, 1'b1);
            @(negedge clk);
            start_ptr = AW'(s);
            end_ptr = AW'(wp);
            ctrl_write(1'b1);
            repeat (3) @(negedge clk);
            check_eq("R8 valid pending", 64'(bus_valid_o), 64'd1);
            held = bus_data_o;
            ctrl_write(1'b0);
            check_eq("R7 enable unchanged while busy", 64'(enable_o), 64'd1);
            check_eq("R7 still busy", 64'(busy_o), 64'd1);
            repeat (4) @(negedge clk);
            check_eq("R8 data held", 64'(bus_data_o), 64'(held));
            ready_mode = 0;
            repeat (8) @(negedge clk);
            check_eq("R7 run completed", 64'(busy_o), 64'd0);
            check_eq("R7 write issued", 64'(exp_q.size()), 64'd0);
            ctrl_write(1'b0);
            check_eq("R7 idle clear of enable", 64'(enable_o), 64'd0);
        end

        // R9: unknown opcode stops the run, flag sticky
        ready_mode = 1;
        begin
            int s;
            s = wp;
            put_single(20'h00111, 4'hF, 32'h1111_1111, 1'b1);
            load_word(wp, 32'h2222_2222);
            load_word(wp + 1, {8'h05, 4'hF, 20'h00222});
            wp += 2;
            put_single(20'h00333, 4'hF, 32'h3333_3333, 1'b0);
            run(s, wp, 1'b1, "R9 bad opcode");
            check_eq("R9 busy low after error", 64'(busy_o), 64'd0);
            s = wp;
            put_single(20'h00444, 4'b0001, 32'h4444_4444, 1'b1);
            run(s, wp, 1'b1, "R9 sticky flag");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule